// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block collects interrupt requests from internal sources and from external pins. The internal sources are two timers and a parameterized group of communication-port and DMA events. The external pins are four maskable inputs and one non-maskable input. Each request sets a sticky pending bit. Maskable requests are gated by a per-source enable vector and by a global enable flag.

Of the eligible pending requests, the one with the smallest table displacement wins. The block then issues a one-cycle take strobe. With the strobe it presents the winner's identifier and a vector address. That address is the 512-word-aligned table base plus the winner's fixed displacement.

The consumer services the interrupt and answers with an acknowledge. The acknowledge clears the served source's pending bit and lets the next winner through. The global enable drops automatically when an interrupt is taken, and software sets it again through a small write port.

Top module: `irq_vector_ctl`

## Requirements
- R1: After a synchronous reset, the block is in a known idle state:
  - the take strobe is low;
  - the global enable reads 0;
  - no source is pending, so nothing is taken until a new request arrives.
- R2: Vector address and source identifiers.
  - The vector address equals the table base with its low 9 bits forced to zero, ORed with the source displacement.
  - Source identifiers and displacements are:
    - id 0: non-maskable input, displacement 0x01;
    - id 1: timer 0, displacement 0x02;
    - ids 2..5: external inputs 0..3, displacements 0x03..0x06;
    - ids 6..6+N_CDMA-1: comm/DMA event j, displacement 0x0D+j;
    - id 6+N_CDMA: timer 1, displacement 0x2B.
- R3: When several requests are eligible, the one with the smallest displacement (smallest id) is taken. This holds whether the requests arrived together or were already waiting.
- R4: A maskable source (id ≥ 1) is taken only when both of these are 1:
  - the global enable;
  - its own bit in `src_en_i` (bit index = source id).
- R5: The non-maskable source (id 0) is taken regardless of the global enable and of `src_en_i`.
- R6: Pin edge detection.
  - An external or non-maskable pin sets its pending bit on a rising edge, seen after a two-flop synchronizer.
  - A pin held high does not set the bit again.
  - Timer and comm/DMA inputs set their pending bit in any cycle they are high.
- R7: A pending bit stays set until that source is acknowledged, even while the source is disabled.
- R8: Take strobe and global enable.
  - `take_o` is a one-cycle pulse.
  - The global enable reads 0 in the same cycle as the pulse.
  - If a global-enable write lands in the cycle of a take, the take wins and the enable ends at 0.
- R9: Acknowledge handling.
  - Only one take is issued per acknowledge.
  - An acknowledge clears the presented source's pending bit.
  - The next eligible source is taken on the cycle after the acknowledge.
  - An acknowledge with no outstanding take is ignored.
- R10: A write with `gie_wr_i` high sets the global enable to `gie_wd_i` from the next cycle, unless a take occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_pin_i | input | 1 | Non-maskable interrupt pin (asynchronous) |
| ext_pin_i | input | 4 | Maskable external interrupt pins (asynchronous) |
| tmr_req_i | input | 2 | Timer 0 / timer 1 request pulses |
| cdma_req_i | input | N_CDMA | Comm-port and DMA request pulses |
| src_en_i | input | N_CDMA+7 | Per-source enable, indexed by source id (bit 0 unused) |
| gie_wr_i | input | 1 | Global enable write strobe |
| gie_wd_i | input | 1 | Global enable write data |
| tbl_base_i | input | ADDR_W | Vector table base |
| ack_i | input | 1 | Acknowledge of the presented interrupt |
| take_o | output | 1 | One-cycle take-interrupt strobe |
| src_id_o | output | $clog2(N_CDMA+7) | Identifier of the taken source |
| vec_addr_o | output | ADDR_W | Vector address of the taken source |
| gie_o | output | 1 | Current global enable |

## Verification
The bench targets the non-contiguous priority order, where timer 1 sits below every comm/DMA event. A design with a plain positional encoder, or with timer 1 slotted next to timer 0, would serve timer 1 too early and give it the wrong vector.

It also probes the following corner cases:
- A base with its low bits set. A design that adds the full base would produce vectors off the table.
- A pin held high across an acknowledge. A level-sensitive design would re-take the source.
- A global-enable write that coincides with a take. A design where the write wins would allow immediate re-entry.
- An acknowledge with nothing outstanding. A design that honours it would lose a waiting request.

Randomized rounds latch sparse request sets with the global enable off, then drain them one acknowledge at a time. Each drain step checks that the next winner appears exactly one cycle after the acknowledge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int BASE_ALIGN = 9;

  // Fixed table displacement of a source, by source id.
  function automatic logic [BASE_ALIGN-1:0] src_disp(input int idx, input int n_cdma);
    if (idx == 0)            return 9'h001;
    else if (idx == 1)       return 9'h002;
    else if (idx < 6)        return 9'(idx + 1);
    else if (idx < 6 + n_cdma) return 9'(13 + idx - 6);
    else                     return 9'h02B;
  endfunction
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;

  // R6
  rise_single_chk: assert property (@(posedge clk) disable iff (rst)
    (rise_o & $past(rise_o)) == '0);
endmodule

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R7
    pend_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      $past(pend_q[i]) && !$past(clr_i[i]) |-> pend_q[i]);
  end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int N    = 8,
  parameter int ID_W = $clog2(N)
) (
  input  logic [N-1:0]    req_i,
  output logic            valid_o,
  output logic [ID_W-1:0] idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        idx_o   = ID_W'(i);
      end
    end
  end

  // R3
  always_comb begin
    if (valid_o) prio_hit_chk: assert (req_i[idx_o]);
    else         prio_none_chk: assert (req_i == '0);
  end
endmodule

// File: rtl/irq_vector_ctl.sv
module irq_vector_ctl #(
  parameter int N_CDMA = 30,
  parameter int ADDR_W = 32,
  localparam int NSRC  = N_CDMA + 7,
  localparam int ID_W  = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nmi_pin_i,
  input  logic [3:0]        ext_pin_i,
  input  logic [1:0]        tmr_req_i,
  input  logic [N_CDMA-1:0] cdma_req_i,
  input  logic [NSRC-1:0]   src_en_i,
  input  logic              gie_wr_i,
  input  logic              gie_wd_i,
  input  logic [ADDR_W-1:0] tbl_base_i,
  input  logic              ack_i,
  output logic              take_o,
  output logic [ID_W-1:0]   src_id_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              gie_o
);
  import irq_pkg::*;

  localparam int TMR1_ID = NSRC - 1;
  localparam int CDMA_LO = 6;

  logic [4:0]        rise;
  logic [NSRC-1:0]   set_v, clr_v, pend, en_mask, elig;
  logic              win_valid, grant;
  logic [ID_W-1:0]   win_id;
  logic [ADDR_W-1:0] base_al;

  logic              busy_q, take_q, gie_q;
  logic [ID_W-1:0]   id_q;
  logic [ADDR_W-1:0] vec_q;

  irq_edge_sync #(.W(5)) u_sync (
    .clk(clk), .rst(rst),
    .pin_i({ext_pin_i, nmi_pin_i}),
    .rise_o(rise)
  );

  always_comb begin
    set_v                         = '0;
    set_v[0]                      = rise[0];
    set_v[1]                      = tmr_req_i[0];
    set_v[5:2]                    = rise[4:1];
    set_v[CDMA_LO +: N_CDMA]      = cdma_req_i;
    set_v[TMR1_ID]                = tmr_req_i[1];
  end

  always_comb begin
    for (int i = 0; i < NSRC; i++)
      clr_v[i] = busy_q & ack_i & (id_q == ID_W'(i));
  end

  irq_pend #(.N(NSRC)) u_pend (
    .clk(clk), .rst(rst),
    .set_i(set_v), .clr_i(clr_v),
    .pend_o(pend)
  );

  assign en_mask = (src_en_i & {NSRC{gie_q}}) | NSRC'(1);
  assign elig    = pend & en_mask;

  irq_prio #(.N(NSRC), .ID_W(ID_W)) u_prio (
    .req_i(elig), .valid_o(win_valid), .idx_o(win_id)
  );

  assign grant   = win_valid & ~busy_q;
  assign base_al = tbl_base_i & ~ADDR_W'(9'h1FF);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      take_q <= 1'b0;
      gie_q  <= 1'b0;
      id_q   <= '0;
      vec_q  <= '0;
    end else begin
      take_q <= grant;
      if (grant) begin
        busy_q <= 1'b1;
        id_q   <= win_id;
        vec_q  <= base_al | ADDR_W'(src_disp(int'(win_id), N_CDMA));
      end else if (ack_i) begin
        busy_q <= 1'b0;
      end
      if (grant)         gie_q <= 1'b0;
      else if (gie_wr_i) gie_q <= gie_wd_i;
    end
  end

  assign take_o     = take_q;
  assign src_id_o   = id_q;
  assign vec_addr_o = vec_q;
  assign gie_o      = gie_q;

  // R8
  take_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    take_o |=> !take_o);
  // R8
  take_gie_clr_chk: assert property (@(posedge clk) disable iff (rst)
    take_o |-> !gie_o);
  // R4
  mask_gie_chk: assert property (@(posedge clk) disable iff (rst)
    take_o && (src_id_o != '0) |-> $past(gie_q));
  // R9
  one_per_ack_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q && !ack_i |=> !take_o);
  // R2
  vec_base_chk: assert property (@(posedge clk) disable iff (rst)
    take_o |-> vec_addr_o[ADDR_W-1:9] == $past(tbl_base_i[ADDR_W-1:9]));
endmodule

// File: tb/irq_vector_ctl_test.sv
module irq_vector_ctl_test;
  localparam int N_CDMA = 30;
  localparam int AW     = 32;
  localparam int NSRC   = N_CDMA + 7;
  localparam int IDW    = $clog2(NSRC);
  localparam int TMR1   = NSRC - 1;

  logic clk = 0, rst = 1;
  logic nmi_pin = 0, gie_wr = 0, gie_wd = 0, ack = 0;
  logic [3:0] ext_pin = '0;
  logic [1:0] tmr_req = '0;
  logic [N_CDMA-1:0] cdma_req = '0;
  logic [NSRC-1:0] src_en = '0;
  logic [AW-1:0] base = 32'h8000_41FF;
  logic take;
  logic [IDW-1:0] src_id;
  logic [AW-1:0] vec;
  logic gie;

  int checks = 0, fails = 0;
  logic [NSRC-1:0] mpend = '0;

  always #5 clk = ~clk;

  irq_vector_ctl #(.N_CDMA(N_CDMA), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .nmi_pin_i(nmi_pin), .ext_pin_i(ext_pin),
    .tmr_req_i(tmr_req), .cdma_req_i(cdma_req), .src_en_i(src_en),
    .gie_wr_i(gie_wr), .gie_wd_i(gie_wd), .tbl_base_i(base), .ack_i(ack),
    .take_o(take), .src_id_o(src_id), .vec_addr_o(vec), .gie_o(gie)
  );

  function automatic logic [8:0] disp_of(input int id);
    if (id == 0) return 9'h01;
    if (id == 1) return 9'h02;
    if (id <= 5) return 9'(3 + id - 2);
    if (id < 6 + N_CDMA) return 9'(8'h0D + id - 6);
    return 9'h2B;
  endfunction

  function automatic logic [AW-1:0] exp_vec(input logic [AW-1:0] b, input int id);
    return {b[AW-1:9], 9'h0} | AW'(disp_of(id));
  endfunction

  function automatic int winner(input logic [NSRC-1:0] p, input logic [NSRC-1:0] en, input bit g);
    for (int i = 0; i < NSRC; i++)
      if (p[i] && (i == 0 || (g && en[i]))) return i;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // Raise a set of maskable sources (ids 1..NSRC-1); no take expected.
  task automatic raise_set(input logic [NSRC-1:0] m);
    tmr_req[0] = m[1];
    ext_pin    = m[5:2];
    cdma_req   = m[6 +: N_CDMA];
    tmr_req[1] = m[TMR1];
    step();
    tmr_req = '0; cdma_req = '0;
    step(); step();
    ext_pin = '0;
    step(); step();
    mpend = mpend | (m & ~NSRC'(1));
  endtask

  task automatic gie_write(input bit v);
    gie_wr = 1; gie_wd = v;
    step();
    gie_wr = 0;
  endtask

  // Enable globally, then drain eligible pending sources one per acknowledge.
  task automatic serve(input string tag);
    int w;
    gie_write(1);
    step();
    forever begin
      w = winner(mpend, src_en, 1'b1);
      if (w < 0) begin
        chk(take == 0, "R4 no eligible source, no take", take, 0);
        break;
      end
      chk(take == 1, {tag, " R9 take on cycle after ack"}, take, 1);
      chk(src_id == IDW'(w), {tag, " R3 winner id"}, src_id, w);
      chk(vec == exp_vec(base, w), {tag, " R2 vector"}, vec, exp_vec(base, w));
      mpend[w] = 1'b0;
      ack = 1; gie_wr = 1; gie_wd = 1;
      step();
      ack = 0; gie_wr = 0;
      step();
    end
    gie_write(0);
    step();
  endtask

  task automatic poll_take(input int maxc, output bit got);
    got = 0;
    for (int c = 0; c < maxc; c++) begin
      step();
      if (take) begin got = 1; break; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    bit got;
    int w;
    void'($urandom(32'd1234));
    repeat (3) step();
    rst = 0;
    step();
    // R1
    chk(take == 0, "R1 take after reset", take, 0);
    chk(gie == 0, "R1 gie after reset", gie, 0);
    repeat (4) step();
    chk(take == 0, "R1 nothing pending after reset", take, 0);

    // R10 write port
    gie_write(1); step();
    chk(gie == 1, "R10 gie set", gie, 1);
    gie_write(0); step();
    chk(gie == 0, "R10 gie clear", gie, 0);

    // R5 non-maskable with gie=0, enables all zero; low base bits ignored (R2)
    src_en = '0;
    nmi_pin = 1;
    poll_take(10, got);
    chk(got, "R5 nmi taken with gie=0", got, 1);
    chk(src_id == 0, "R5 nmi id", src_id, 0);
    chk(vec == 32'h8000_4001, "R2 nmi vector low bits ignored", vec, 32'h8000_4001);
    // timer0 arrives while nmi outstanding
    src_en[1] = 1;
    tmr_req[0] = 1; step(); tmr_req[0] = 0;
    repeat (3) step();
    chk(take == 0, "R9 no second take before ack", take, 0);
    ack = 1; step(); ack = 0; step();
    chk(take == 0, "R4 timer0 held off with gie=0", take, 0);
    ack = 1; step(); ack = 0; step();   // ack with nothing outstanding
    chk(take == 0, "R9 idle ack ignored", take, 0);
    nmi_pin = 0;
    gie_write(1); step();
    chk(take == 1 && src_id == 1, "R7 timer0 still pending after idle ack", src_id, 1);
    chk(vec == 32'h8000_4002, "R2 timer0 vector", vec, 32'h8000_4002);
    ack = 1; step(); ack = 0;

    // R6 held level does not retrigger
    src_en = '0; src_en[2] = 1;
    ext_pin[0] = 1;
    gie_write(1);
    poll_take(10, got);
    chk(got && src_id == 2, "R6 ext0 edge taken", src_id, 2);
    ack = 1; gie_wr = 1; gie_wd = 1; step(); ack = 0; gie_wr = 0;
    got = 0;
    for (int c = 0; c < 10; c++) begin step(); if (take) got = 1; end
    chk(!got, "R6 held pin no retrigger", got, 0);
    ext_pin[0] = 0;
    gie_write(0); step();

    // R8 take beats simultaneous gie write; timer1 lowest
    src_en = '0; src_en[TMR1] = 1;
    tmr_req[1] = 1; step(); tmr_req[1] = 0; step();
    gie_wr = 1; gie_wd = 1;
    step();            // gie becomes 1
    step();            // take edge, write still active
    gie_wr = 0;
    chk(take == 1 && src_id == IDW'(TMR1), "R8 timer1 taken", src_id, TMR1);
    chk(vec == exp_vec(base, TMR1), "R2 timer1 vector 0x2B", vec, exp_vec(base, TMR1));
    chk(gie == 0, "R8 take wins over gie write", gie, 0);
    step();
    chk(take == 0, "R8 strobe one cycle", take, 1'b0);
    ack = 1; step(); ack = 0; step();

    // R3 directed: timer1 vs last comm/DMA vs ext3 arriving together
    src_en = '1;
    raise_set((NSRC'(1) << TMR1) | (NSRC'(1) << (TMR1 - 1)) | (NSRC'(1) << 5));
    chk(take == 0, "R4 no take with gie=0", take, 0);
    serve("directed");

    // Random rounds
    for (int r = 0; r < 60; r++) begin
      logic [NSRC-1:0] m;
      base = $urandom;
      for (int i = 0; i < NSRC; i++) begin
        m[i] = ($urandom % 4) == 0;
        src_en[i] = ($urandom % 3) != 0;
      end
      m[0] = 1'b0;
      raise_set(m);
      chk(take == 0, "R4 random no take with gie=0", take, 0);
      serve("random");
    end
    // Final drain: disabled sources kept their pending bits (R7)
    src_en = '1;
    w = winner(mpend, src_en, 1'b1);
    serve("R7 drain");
    chk(mpend == '0, "R7 drain completes", w, w);

    finish_run();
  end
endmodule